// File: doc/BRIEF.md
# I2S Bit-Clock and Word-Select Generator

This block produces the serial bit clock and the word-select (left/right) clock of an I2S link from the master clock it runs on. In master mode it divides the master clock in two stages: a bit-clock divisor of 2 or 4, then a word-select divisor of 32, 64 or 128 bit clocks per frame. In slave mode it gates the bit clock and word select supplied by the external device and passes them on. Both directions rely on it for frame timing: it emits a one-cycle frame-start strobe per direction at the start of every left-channel phase.

The block owns the transmit and receive enables and the interface enable derived from them. Clocks run only while at least one direction is enabled, unless a free-run control keeps them going. The divisors can be chosen directly, or picked automatically from the ratio of master clock to sample rate. A new divisor choice never cuts a frame short: it is taken up at the next frame boundary.

Top module: `i2s_clk_gen`

## Requirements
- R1: After reset the enables are cleared and `bclk`, `ws`, both strobes and `ifaceEn` are low.
- R2: In master mode `bclk` has a period of 2 master cycles when `bclkDivSel`=0 and 4 when it is 1, with 50% duty. It is low in the first master cycle of each frame.
- R3: In master mode `ws` is low (left) for the first half of a frame and high for the second half. One half lasts wsDiv/2 bit clocks, where `wsDivSel` 00 gives wsDiv=32, 01 gives 64, and 10 or 11 give 128.
- R4: With `autoSel` high, `ratio` > 384 selects bit-clock divisor 4 and word-select divisor 128. Otherwise word-select divisor 64 is used, with bit-clock divisor 2 if `ratio` < 192 and 4 if not.
- R5: While master generation runs, a divisor change is taken up only at the end of a frame, so the frame in progress keeps its full length. While generation is stopped, the selection is loaded every cycle.
- R6: A frame-start strobe is high for exactly one master cycle at the start of each left phase. In master mode this is the first cycle of a frame. In slave mode it follows a falling edge of `extWs` through a two-stage synchronizer. `txFrameStart` and `rxFrameStart` are each qualified by their own registered enable.
- R7: `ifaceEn` goes high one cycle after the first direction is enabled. It stays high until both directions are disabled, then goes low one cycle later.
- R8: With neither direction enabled and `noGate` low, `bclk` and `ws` are held low. With `noGate` high in master mode, they keep running.
- R9: In slave mode, while running, `bclk` equals `extBclk` and `ws` equals `extWs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txEnable | input | 1 | Transmit direction enable |
| rxEnable | input | 1 | Receive direction enable |
| masterMode | input | 1 | 1: generate clocks, 0: pass external clocks |
| noGate | input | 1 | Keep clocks running with no direction enabled |
| autoSel | input | 1 | Pick divisors from `ratio` |
| ratio | input | RATIO_W | Master clock to sample rate ratio |
| bclkDivSel | input | 1 | 0: divide by 2, 1: divide by 4 |
| wsDivSel | input | 2 | Bit clocks per frame: 00=32, 01=64, 1x=128 |
| extBclk | input | 1 | Bit clock from the external device |
| extWs | input | 1 | Word select from the external device |
| bclk | output | 1 | Bit clock to the serializers |
| ws | output | 1 | Word select, low on left channel |
| txFrameStart | output | 1 | Transmit frame-start strobe |
| rxFrameStart | output | 1 | Receive frame-start strobe |
| ifaceEn | output | 1 | Interface enable |

## Verification
The hardest case to reach is a divisor change that arrives in the middle of a long frame, because the frame in progress must not be shortened. The stimulus starts a 512-cycle frame, waits for a frame-start strobe, and changes the selection 100 cycles into that frame. It then measures the two strobe intervals that follow: the first must still be 512 and the second 64. The automatic selection is driven at the exact thresholds 384, 385, 192 and 191, each measured on the second frame after the change.

// File: rtl/i2s_clk_pkg.sv
package i2s_clk_pkg;
  // log2 of the largest divisors in each stage
  localparam int BSH_MAX = 2;
  localparam int WSH_MAX = 7;
  localparam int CNT_W   = BSH_MAX + WSH_MAX;

  // control-to-datapath bundle
  typedef struct packed {
    logic       runMaster;
    logic       runSlave;
    logic [1:0] bSh;   // log2 of bit-clock divisor
    logic [2:0] wSh;   // log2 of word-select divisor
  } clkCtrl_t;
endpackage

// File: rtl/i2s_clk_ctrl.sv
module i2s_clk_ctrl
  import i2s_clk_pkg::*;
#(
  parameter int RATIO_W = 12,
  parameter int AUTO_HI = 384,
  parameter int AUTO_LO = 192
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               txEnable,
  input  logic               rxEnable,
  input  logic               masterMode,
  input  logic               noGate,
  input  logic               autoSel,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               bclkDivSel,
  input  logic [1:0]         wsDivSel,
  input  logic               frameEnd,
  output clkCtrl_t           ctrl,
  output logic               txOn,
  output logic               rxOn,
  output logic               ifaceEn
);
  localparam logic [RATIO_W-1:0] HI_L = RATIO_W'(AUTO_HI);
  localparam logic [RATIO_W-1:0] LO_L = RATIO_W'(AUTO_LO);

  logic       txQ, rxQ, ngQ, msQ;
  logic [1:0] bShQ, bShNext;
  logic [2:0] wShQ, wShNext;
  logic       runAny, load;

  always_comb begin
    if (autoSel) begin
      if (ratio > HI_L) begin
        bShNext = 2'd2;
        wShNext = 3'd7;
      end else begin
        wShNext = 3'd6;
        bShNext = (ratio < LO_L) ? 2'd1 : 2'd2;
      end
    end else begin
      bShNext = bclkDivSel ? 2'd2 : 2'd1;
      case (wsDivSel)
        2'b00:   wShNext = 3'd5;
        2'b01:   wShNext = 3'd6;
        default: wShNext = 3'd7;
      endcase
    end
  end

  assign runAny = txQ | rxQ | ngQ;
  assign load   = !(runAny && msQ) || frameEnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txQ  <= 1'b0;
      rxQ  <= 1'b0;
      ngQ  <= 1'b0;
      msQ  <= 1'b0;
      bShQ <= 2'd1;
      wShQ <= 3'd5;
    end else begin
      txQ <= txEnable;
      rxQ <= rxEnable;
      ngQ <= noGate;
      msQ <= masterMode;
      if (load) begin
        bShQ <= bShNext;
        wShQ <= wShNext;
      end
    end
  end

  assign ctrl.runMaster = runAny && msQ;
  assign ctrl.runSlave  = runAny && !msQ;
  assign ctrl.bSh       = bShQ;
  assign ctrl.wSh       = wShQ;
  assign txOn           = txQ;
  assign rxOn           = rxQ;
  assign ifaceEn        = txQ | rxQ;

  assert_div_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.runMaster && $past(ctrl.runMaster) && !$past(frameEnd))
      |-> ($stable(bShQ) && $stable(wShQ)));
endmodule

// File: rtl/i2s_clk_dp.sv
module i2s_clk_dp
  import i2s_clk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  clkCtrl_t ctrl,
  input  logic     txOn,
  input  logic     rxOn,
  input  logic     extBclk,
  input  logic     extWs,
  output logic     bclk,
  output logic     ws,
  output logic     txFrameStart,
  output logic     rxFrameStart,
  output logic     frameEnd
);
  logic [CNT_W-1:0] cnt, lastCnt, shB, shW;
  logic [3:0]       totSh;
  logic             wsS1, wsS2, wsS3;
  logic             fsAny;

  assign totSh   = {2'b00, ctrl.bSh} + {1'b0, ctrl.wSh};
  assign lastCnt = (CNT_W'(1) << totSh) - CNT_W'(1);
  assign frameEnd = ctrl.runMaster && (cnt == lastCnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      wsS1 <= 1'b0;
      wsS2 <= 1'b0;
      wsS3 <= 1'b0;
    end else begin
      if (!ctrl.runMaster || frameEnd) cnt <= '0;
      else                             cnt <= cnt + CNT_W'(1);
      wsS1 <= extWs;
      wsS2 <= wsS1;
      wsS3 <= wsS2;
    end
  end

  assign shB = cnt >> (ctrl.bSh - 2'd1);
  assign shW = cnt >> (totSh - 4'd1);

  always_comb begin
    if (ctrl.runMaster) begin
      bclk  = shB[0];
      ws    = shW[0];
      fsAny = (cnt == '0);
    end else if (ctrl.runSlave) begin
      bclk  = extBclk;
      ws    = extWs;
      fsAny = wsS3 && !wsS2;
    end else begin
      bclk  = 1'b0;
      ws    = 1'b0;
      fsAny = 1'b0;
    end
  end

  assign txFrameStart = fsAny && txOn;
  assign rxFrameStart = fsAny && rxOn;

  assert_bclk_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.runMaster && $past(ctrl.runMaster) && ctrl.bSh == 2'd1 && $stable(ctrl.bSh))
      |-> (bclk != $past(bclk)));

  assert_ws_on_bclk_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.runMaster && $past(ctrl.runMaster) && ws != $past(ws))
      |-> (!bclk && $past(bclk)));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fsAny |=> !fsAny);
endmodule

// File: rtl/i2s_clk_gen.sv
module i2s_clk_gen
  import i2s_clk_pkg::*;
#(
  parameter int RATIO_W = 12,
  parameter int AUTO_HI = 384,
  parameter int AUTO_LO = 192
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               txEnable,
  input  logic               rxEnable,
  input  logic               masterMode,
  input  logic               noGate,
  input  logic               autoSel,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               bclkDivSel,
  input  logic [1:0]         wsDivSel,
  input  logic               extBclk,
  input  logic               extWs,
  output logic               bclk,
  output logic               ws,
  output logic               txFrameStart,
  output logic               rxFrameStart,
  output logic               ifaceEn
);
  clkCtrl_t ctrlBus;
  logic     txOn, rxOn, frameEnd;

  i2s_clk_ctrl #(.RATIO_W(RATIO_W), .AUTO_HI(AUTO_HI), .AUTO_LO(AUTO_LO)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .txEnable(txEnable), .rxEnable(rxEnable),
    .masterMode(masterMode), .noGate(noGate), .autoSel(autoSel), .ratio(ratio),
    .bclkDivSel(bclkDivSel), .wsDivSel(wsDivSel), .frameEnd(frameEnd),
    .ctrl(ctrlBus), .txOn(txOn), .rxOn(rxOn), .ifaceEn(ifaceEn)
  );

  i2s_clk_dp dp_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrlBus), .txOn(txOn), .rxOn(rxOn),
    .extBclk(extBclk), .extWs(extWs), .bclk(bclk), .ws(ws),
    .txFrameStart(txFrameStart), .rxFrameStart(rxFrameStart), .frameEnd(frameEnd)
  );

  assert_strobe_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (txFrameStart || rxFrameStart) |-> ifaceEn);
endmodule

// File: tb/i2s_clk_gen_tb_top.sv
module i2s_clk_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txEnable = 0, rxEnable = 0, masterMode = 1, noGate = 0, autoSel = 0;
  logic [11:0] ratio = 12'd0;
  logic bclkDivSel = 0;
  logic [1:0] wsDivSel = 2'b00;
  logic extBclk = 0, extWs = 0;
  logic bclk, ws, txFrameStart, rxFrameStart, ifaceEn;

  int checks = 0;
  int errors = 0;
  bit cmpOn = 0;

  always #5 clk = ~clk;

  i2s_clk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .txEnable(txEnable), .rxEnable(rxEnable),
    .masterMode(masterMode), .noGate(noGate), .autoSel(autoSel), .ratio(ratio),
    .bclkDivSel(bclkDivSel), .wsDivSel(wsDivSel), .extBclk(extBclk), .extWs(extWs),
    .bclk(bclk), .ws(ws), .txFrameStart(txFrameStart), .rxFrameStart(rxFrameStart),
    .ifaceEn(ifaceEn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mPhase = 0;
  int mB = 2, mW = 32;
  bit mTx = 0, mRx = 0, mNg = 0, mMs = 0;
  bit s1 = 0, s2 = 0, s3 = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mPhase = 0; mB = 2; mW = 32;
      mTx = 0; mRx = 0; mNg = 0; mMs = 0;
      s1 = 0; s2 = 0; s3 = 0;
    end else begin
      bit runM, fEnd;
      runM = (mTx | mRx | mNg) & mMs;
      fEnd = runM && (mPhase == mB * mW - 1);
      if (!runM || fEnd) begin
        mPhase = 0;
        if (autoSel) begin
          if (ratio > 384) begin mB = 4; mW = 128; end
          else begin mW = 64; mB = (ratio < 192) ? 2 : 4; end
        end else begin
          mB = bclkDivSel ? 4 : 2;
          mW = (wsDivSel == 2'b00) ? 32 : (wsDivSel == 2'b01) ? 64 : 128;
        end
      end else mPhase++;
      mTx = txEnable; mRx = rxEnable; mNg = noGate; mMs = masterMode;
      s3 = s2; s2 = s1; s1 = extWs;
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      bit run, runM, runS, eB, eW, eF;
      run  = mTx | mRx | mNg;
      runM = run & mMs;
      runS = run & !mMs;
      if (runM) begin
        eB = ((mPhase / (mB / 2)) % 2) == 1;
        eW = ((mPhase / (mB * mW / 2)) % 2) == 1;
        eF = (mPhase == 0);
      end else if (runS) begin
        eB = extBclk; eW = extWs; eF = s3 && !s2;
      end else begin
        eB = 0; eW = 0; eF = 0;
      end
      chk(runS ? "R9 bclk" : "R2/R8 bclk", int'(bclk), int'(eB));
      chk(runS ? "R9 ws" : "R3/R8 ws", int'(ws), int'(eW));
      chk("R6 txFrameStart", int'(txFrameStart), int'(eF && mTx));
      chk("R6 rxFrameStart", int'(rxFrameStart), int'(eF && mRx));
      chk("R7 ifaceEn", int'(ifaceEn), int'(mTx | mRx));
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic nextStrobe();
    do @(negedge clk); while (!txFrameStart);
  endtask

  task automatic interval(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!txFrameStart);
  endtask

  task automatic autoFrame(input int r, input int exp, input string tag);
    int n;
    cyc(1);
    ratio = 12'(r);
    nextStrobe();
    interval(n);
    interval(n);
    chk(tag, n, exp);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, tog;
    bit prevB;
    cyc(3);
    @(negedge clk);
    // R1 reset state
    chk("R1 bclk", int'(bclk), 0);
    chk("R1 ws", int'(ws), 0);
    chk("R1 txFrameStart", int'(txFrameStart), 0);
    chk("R1 ifaceEn", int'(ifaceEn), 0);
    cmpOn = 1;
    cyc(1); rst_n = 1;
    cyc(2);

    // master, divide 2 / 32, transmit only
    txEnable = 1;
    cyc(300);
    // R7: add receive, drop transmit, interface stays on
    rxEnable = 1; cyc(40);
    txEnable = 0; cyc(3);
    @(negedge clk); chk("R7 stays on with rx", int'(ifaceEn), 1);
    cyc(1);
    rxEnable = 0; cyc(3);
    @(negedge clk); chk("R7 off after both off", int'(ifaceEn), 0);
    // R8 gated low
    tog = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bclk || ws) tog++;
    end
    chk("R8 gated clocks high count", tog, 0);
    // R8 free run with noGate
    cyc(1); noGate = 1; cyc(3);
    @(negedge clk); prevB = bclk; tog = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bclk != prevB) tog++;
      prevB = bclk;
    end
    chk("R8 free-run toggles", tog, 20);
    cyc(1); noGate = 0; cyc(3);

    // R2/R3 other manual settings
    bclkDivSel = 1; wsDivSel = 2'b01; txEnable = 1; rxEnable = 1;
    cyc(600);
    wsDivSel = 2'b11; cyc(1100);

    // R5 change in mid-frame: 4/128 frame is 512 cycles
    bclkDivSel = 1; wsDivSel = 2'b10; cyc(600);
    nextStrobe();
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 100) begin bclkDivSel = 0; wsDivSel = 2'b00; end
    end while (!txFrameStart);
    chk("R5 frame in progress kept", n, 512);
    interval(n);
    chk("R5 new frame length", n, 64);

    // R4 automatic selection
    autoSel = 1;
    autoFrame(500, 512, "R4 ratio 500");
    autoFrame(385, 512, "R4 ratio 385");
    autoFrame(384, 256, "R4 ratio 384");
    autoFrame(300, 256, "R4 ratio 300");
    autoFrame(192, 256, "R4 ratio 192");
    autoFrame(191, 128, "R4 ratio 191");
    autoFrame(100, 128, "R4 ratio 100");
    cyc(1); autoSel = 0; txEnable = 0; rxEnable = 0; cyc(4);

    // R9 slave pass-through and R6 synchronized strobe
    masterMode = 0; cyc(2);
    txEnable = 1; rxEnable = 1;
    tog = 0;
    for (int k = 0; k < 520; k++) begin
      extBclk = ((k / 2) % 2) == 1;
      extWs   = ((k / 128) % 2) == 1;
      @(negedge clk);
      if (txFrameStart) tog++;
      if (k == 50) chk("R9 bclk follows ext", int'(bclk), int'(extBclk));
      @(posedge clk); #2;
    end
    chk("R6 slave strobe count", tog, 2);
    extWs = 0; extBclk = 0;
    txEnable = 0; rxEnable = 0;
    cyc(5);

    cmpOn = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule